// File: doc/BRIEF.md
# Round-to-Odd Double-to-Single Narrowing Converter

This block takes one or two IEEE 754 binary64 values and narrows each to binary32 with the round-to-odd rule. The result is first truncated. If any bits were lost, the lowest fraction bit of the result is then set to one. A later rounding step to an even narrower format can then round correctly, with no double-rounding error. Each binary64 lane yields one binary32 result. The two results together form a 64-bit result word. That word is written into a 128-bit destination in one of three ways:

- the lower half, with the upper half cleared;
- the upper half, with the old lower half kept;
- as a scalar (lane 0 only), where a merge control decides whether the rest of the old destination is kept or zeroed.

A request is presented with `in_valid_i`. The new destination and four exception flags are registered and appear one clock later with `out_valid_o`. Each flag is the OR of that flag over the active lanes of that one request.

Top module: `ron_narrow`

## Requirements
- R1: Lane e reads source bits [64e+63:64e] and writes result-word bits [32e+31:32e]. A finite value that fits binary32 exactly converts to its exact binary32 encoding and raises no flag.
- R2: When nonzero bits are discarded, the result is the truncated value with fraction bit 0 forced to 1, and the inexact flag is raised. This includes values exactly halfway between two binary32 numbers.
- R3: A finite magnitude of 2^128 or more gives the largest finite binary32 of the same sign (exponent 0xFE, fraction all ones), with overflow and inexact raised. A finite input never produces exponent 0xFF.
- R4: A result below 2^-126 is denormalized (biased exponent 0). All bits shifted out count toward the sticky bit, and round-to-odd is then applied. Underflow is raised exactly when such a tiny result is inexact. An exact subnormal result raises no flag.
- R5: A binary64 subnormal input gives the smallest binary32 subnormal of the same sign (0x00000001 or 0x80000001), with underflow and inexact raised.
- R6: A NaN input gives exponent 0xFF, fraction bit 22 set (quiet), fraction bits [21:0] equal to source fraction bits [50:29], and the source sign. Invalid is raised only when source fraction bit 51 is 0 (signalling).
- R7: Infinities and zeros convert exactly, keep their sign and raise no flag.
- R8: Vector lower-half variant (`vector_mode_i`=1, `upper_half_i`=0): destination [63:0] is the result word and [127:64] is zero.
- R9: Vector upper-half variant (`vector_mode_i`=1, `upper_half_i`=1): destination [127:64] is the result word and [63:0] equals the old destination [63:0].
- R10: Scalar form (`vector_mode_i`=0) converts lane 0 only into destination [31:0]. With `merge_en_i`=1, bits [127:32] come from the old destination. With `merge_en_i`=0 they are zero. `upper_half_i` has no effect in scalar form.
- R11: In scalar form, source bits [127:64] have no effect on the destination or on any flag.
- R12: Results and flags appear one clock after `in_valid_i`, with `out_valid_o` high for that one cycle. In vector form each flag is the OR over both lanes. After reset, `out_valid_o`, the destination and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Request present this cycle |
| src_i | input | 128 | Two binary64 source lanes |
| old_dst_i | input | 128 | Previous destination contents |
| upper_half_i | input | 1 | Vector form: 1 writes the upper half, 0 writes the lower half |
| vector_mode_i | input | 1 | 1 for two-lane vector form, 0 for scalar |
| merge_en_i | input | 1 | Scalar form: keep old destination bits above the result |
| out_valid_o | output | 1 | Result registered this cycle |
| dst_o | output | 128 | New destination contents |
| flag_inexact_o | output | 1 | Some discarded bit was nonzero |
| flag_overflow_o | output | 1 | Magnitude exceeded binary32 range |
| flag_underflow_o | output | 1 | Tiny and inexact result |
| flag_invalid_o | output | 1 | Signalling NaN input |

## Verification
The bench builds the block with its default parameters: binary64 source lanes (11-bit exponent, 52-bit fraction), binary32 results (8-bit exponent, 23-bit fraction) and two lanes. With these values the 896 exponent bias gap is in play, so the bench can reach the exact overflow edge at 2^128 and the subnormal edges at 2^-127, 2^-149 and 2^-150. Two lanes also let the bench put different special values side by side, which tests the OR of the flags across lanes and the lane placement in both halves.

// File: rtl/ron_pkg.sv
// Package: shared types for the round-to-odd narrowing converter.
// Assumes: one exception-flag group per lane, ORed at the top.
package ron_pkg;

    // Input classes that choose the conversion path
    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_INF,
        CLS_NAN,
        CLS_NORM,
        CLS_OVF,
        CLS_SUB
    } ron_class_e;

    // Exception flags raised by one lane
    typedef struct packed {
        logic inexact;
        logic overflow;
        logic underflow;
        logic invalid;
    } ron_flags_t;

    localparam int FLAG_W = 4;

endpackage

// File: rtl/ron_classify.sv
// Module: ron_classify
// Sorts a wide-format exponent/fraction pair into the conversion path
// that the narrowing lane must take.
// Assumes: both formats are biased IEEE-style layouts, and the narrow
// exponent range lies inside the wide one.
module ron_classify
    import ron_pkg::*;
#(
    parameter int SEW = 11,
    parameter int SFW = 52,
    parameter int DEW = 8
) (
    input  logic [SEW-1:0] exp_i,
    input  logic [SFW-1:0] frac_i,
    output ron_class_e     cls_o
);
    localparam int SRC_EMAX = (1 << SEW) - 1;
    localparam int SRC_BIAS = (1 << (SEW - 1)) - 1;
    localparam int DST_BIAS = (1 << (DEW - 1)) - 1;
    localparam int DST_EMAX = (1 << DEW) - 1;
    localparam int BIAS_GAP = SRC_BIAS - DST_BIAS;
    localparam int OVF_EXP  = BIAS_GAP + DST_EMAX;

    // Decide the path from the exponent range and the fraction contents
    always_comb begin
        if (int'(exp_i) == SRC_EMAX) begin
            cls_o = (frac_i == '0) ? CLS_INF : CLS_NAN;
        end else if (exp_i == '0 && frac_i == '0) begin
            cls_o = CLS_ZERO;
        end else if (int'(exp_i) >= OVF_EXP) begin
            cls_o = CLS_OVF;
        end else if (int'(exp_i) > BIAS_GAP) begin
            cls_o = CLS_NORM;
        end else begin
            cls_o = CLS_SUB;
        end
    end

endmodule

// File: rtl/ron_lane.sv
// Module: ron_lane
// Narrows one wide floating-point value to the narrow format with
// round-to-odd: the value is truncated, then fraction bit 0 is ORed
// with a sticky bit made from every discarded bit.
// Assumes: SFW > DFW, SEW > DEW; purely combinational.
module ron_lane
    import ron_pkg::*;
#(
    parameter int SEW = 11,
    parameter int SFW = 52,
    parameter int DEW = 8,
    parameter int DFW = 23,
    localparam int SRC_W = 1 + SEW + SFW,
    localparam int DST_W = 1 + DEW + DFW
) (
    input  logic [SRC_W-1:0] src_i,
    output logic [DST_W-1:0] res_o,
    output ron_flags_t       flags_o
);
    localparam int SRC_BIAS = (1 << (SEW - 1)) - 1;
    localparam int DST_BIAS = (1 << (DEW - 1)) - 1;
    localparam int BIAS_GAP = SRC_BIAS - DST_BIAS;
    localparam int DROP     = SFW - DFW;
    localparam int SIG_W    = SFW + 1;
    localparam int DEN_BASE = DROP + 1;
    localparam int PAY_W    = DFW - 1;

    logic             sign;
    logic [SEW-1:0]   exp_w;
    logic [SFW-1:0]   frac_w;
    ron_class_e       cls;
    logic [SIG_W-1:0] sig;
    logic [DFW-1:0]   norm_frac;
    logic             norm_sticky;
    logic [DEW-1:0]   norm_exp;
    logic [DFW-1:0]   sub_frac;
    logic             sub_sticky;
    logic [SIG_W-1:0] lost_mask;
    int               sub_shift;

    assign sign   = src_i[SRC_W-1];
    assign exp_w  = src_i[SFW +: SEW];
    assign frac_w = src_i[SFW-1:0];

    ron_classify #(.SEW(SEW), .SFW(SFW), .DEW(DEW)) u_classify (
        .exp_i  (exp_w),
        .frac_i (frac_w),
        .cls_o  (cls)
    );

    // Normal path: drop the low fraction bits and rebias the exponent
    always_comb begin
        norm_frac   = frac_w[SFW-1 -: DFW];
        norm_sticky = |frac_w[DROP-1:0];
        norm_exp    = DEW'(int'(exp_w) - BIAS_GAP);
    end

    // Subnormal path: shift the full significand right, collect lost bits
    always_comb begin
        sig       = {(exp_w != '0), frac_w};
        sub_shift = DEN_BASE + BIAS_GAP - ((exp_w == '0) ? 1 : int'(exp_w));
        if (sub_shift >= SIG_W) begin
            lost_mask = '1;
            sub_frac  = '0;
        end else begin
            lost_mask = (SIG_W'(1) << sub_shift) - SIG_W'(1);
            sub_frac  = DFW'(sig >> sub_shift);
        end
        sub_sticky = |(sig & lost_mask);
    end

    // Select the result encoding and flags for the input class
    always_comb begin
        flags_o = '0;
        res_o   = '0;
        unique case (cls)
            CLS_ZERO: res_o = {sign, {(DST_W-1){1'b0}}};
            CLS_INF:  res_o = {sign, {DEW{1'b1}}, {DFW{1'b0}}};
            CLS_NAN: begin
                res_o = {sign, {DEW{1'b1}}, 1'b1, frac_w[SFW-2 -: PAY_W]};
                flags_o.invalid = ~frac_w[SFW-1];
            end
            CLS_OVF: begin
                res_o = {sign, {(DEW-1){1'b1}}, 1'b0, {DFW{1'b1}}};
                flags_o.overflow = 1'b1;
                flags_o.inexact  = 1'b1;
            end
            CLS_NORM: begin
                res_o = {sign, norm_exp, norm_frac[DFW-1:1],
                         norm_frac[0] | norm_sticky};
                flags_o.inexact = norm_sticky;
            end
            default: begin
                res_o = {sign, {DEW{1'b0}}, sub_frac[DFW-1:1],
                         sub_frac[0] | sub_sticky};
                flags_o.inexact   = sub_sticky;
                flags_o.underflow = sub_sticky;
            end
        endcase
    end

    // Guard the range rules next to the result mux
    always_comb begin
        if (cls != CLS_INF && cls != CLS_NAN) begin
            p_finite_stays_finite_r3: assert (res_o[DFW +: DEW] != {DEW{1'b1}});
        end
        if (flags_o.underflow) begin
            p_tiny_has_zero_exp_r4: assert (res_o[DFW +: DEW] == '0);
        end
        if (cls == CLS_NAN) begin
            p_nan_is_quiet_r6: assert (res_o[DFW-1]);
        end
    end

endmodule

// File: rtl/ron_place.sv
// Module: ron_place
// Places the narrowed result word into the destination register image
// according to the vector half or scalar merge controls.
// Assumes: the destination is exactly twice the result word width.
module ron_place #(
    parameter int LANES = 2,
    parameter int LW    = 32,
    localparam int HALF_W = LANES * LW,
    localparam int VEC_W  = 2 * HALF_W
) (
    input  logic [HALF_W-1:0] word_i,
    input  logic [VEC_W-1:0]  old_i,
    input  logic              upper_half_i,
    input  logic              vector_mode_i,
    input  logic              merge_en_i,
    output logic [VEC_W-1:0]  dst_o
);
    // Choose which old bits survive and where the new word lands
    always_comb begin
        if (vector_mode_i) begin
            if (upper_half_i) begin
                dst_o = {word_i, old_i[HALF_W-1:0]};
            end else begin
                dst_o = {{HALF_W{1'b0}}, word_i};
            end
        end else if (merge_en_i) begin
            dst_o = {old_i[VEC_W-1:LW], word_i[LW-1:0]};
        end else begin
            dst_o = {{(VEC_W-LW){1'b0}}, word_i[LW-1:0]};
        end
    end

endmodule

// File: rtl/ron_narrow.sv
// Module: ron_narrow (top)
// Multi-lane wide-to-narrow floating-point converter with round-to-odd,
// destination placement and a single output register stage.
// Assumes: one request per in_valid cycle; outputs hold between requests.
module ron_narrow
    import ron_pkg::*;
#(
    parameter int LANES = 2,
    parameter int SEW   = 11,
    parameter int SFW   = 52,
    parameter int DEW   = 8,
    parameter int DFW   = 23,
    localparam int SRC_W  = 1 + SEW + SFW,
    localparam int DST_W  = 1 + DEW + DFW,
    localparam int HALF_W = LANES * DST_W,
    localparam int VEC_W  = 2 * HALF_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid_i,
    input  logic [LANES*SRC_W-1:0] src_i,
    input  logic [VEC_W-1:0]       old_dst_i,
    input  logic                   upper_half_i,
    input  logic                   vector_mode_i,
    input  logic                   merge_en_i,
    output logic                   out_valid_o,
    output logic [VEC_W-1:0]       dst_o,
    output logic                   flag_inexact_o,
    output logic                   flag_overflow_o,
    output logic                   flag_underflow_o,
    output logic                   flag_invalid_o
);
    logic [HALF_W-1:0] word;
    ron_flags_t        lane_flags [LANES];
    logic [FLAG_W-1:0] flags_acc;
    logic [VEC_W-1:0]  dst_nxt;
    ron_flags_t        flags_q;

    // One converter per lane, lane e maps to result-word slot e
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ron_lane #(.SEW(SEW), .SFW(SFW), .DEW(DEW), .DFW(DFW)) u_lane (
            .src_i   (src_i[g*SRC_W +: SRC_W]),
            .res_o   (word[g*DST_W +: DST_W]),
            .flags_o (lane_flags[g])
        );
    end

    // OR the flags of the lanes that the form actually converts
    always_comb begin
        flags_acc = '0;
        for (int l = 0; l < LANES; l++) begin
            if (vector_mode_i || l == 0) begin
                flags_acc = flags_acc | lane_flags[l];
            end
        end
    end

    ron_place #(.LANES(LANES), .LW(DST_W)) u_place (
        .word_i        (word),
        .old_i         (old_dst_i),
        .upper_half_i  (upper_half_i),
        .vector_mode_i (vector_mode_i),
        .merge_en_i    (merge_en_i),
        .dst_o         (dst_nxt)
    );

    // Output register: capture a request, clear everything on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            dst_o       <= '0;
            flags_q     <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                dst_o   <= dst_nxt;
                flags_q <= ron_flags_t'(flags_acc);
            end
        end
    end

    assign flag_inexact_o   = flags_q.inexact;
    assign flag_overflow_o  = flags_q.overflow;
    assign flag_underflow_o = flags_q.underflow;
    assign flag_invalid_o   = flags_q.invalid;

    // Overflow is always reported together with inexact
    p_ovf_with_inexact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && flag_overflow_o |-> flag_inexact_o);

    // Underflow is only reported for an inexact tiny result
    p_uf_with_inexact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && flag_underflow_o |-> flag_inexact_o);

    // Lower-half vector variant clears the upper half
    p_lower_clears_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && vector_mode_i && !upper_half_i |=> dst_o[VEC_W-1:HALF_W] == '0);

    // Upper-half vector variant keeps the old lower half
    p_upper_keeps_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && vector_mode_i && upper_half_i
        |=> dst_o[HALF_W-1:0] == $past(old_dst_i[HALF_W-1:0]));

    // Scalar merge keeps everything above lane 0
    p_scalar_merge_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && !vector_mode_i && merge_en_i
        |=> dst_o[VEC_W-1:DST_W] == $past(old_dst_i[VEC_W-1:DST_W]));

    // Scalar without merge zeroes everything above lane 0
    p_scalar_plain_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && !vector_mode_i && !merge_en_i |=> dst_o[VEC_W-1:DST_W] == '0);

    // Results appear exactly one cycle after a request
    p_valid_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);

    p_valid_drops_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);

endmodule

// File: tb/ron_narrow_tb.sv
// Directed bench for ron_narrow; reference model is an independent
// bit-position search plus truncation and sticky-OR.
module ron_narrow_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src = '0;
    logic [127:0] old_dst = '0;
    logic         upper_half = 1'b0;
    logic         vector_mode = 1'b0;
    logic         merge_en = 1'b0;
    logic         out_valid;
    logic [127:0] dst;
    logic         f_nx, f_of, f_uf, f_nv;

    int checks = 0;
    int failures = 0;

    ron_narrow u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .in_valid_i       (in_valid),
        .src_i            (src),
        .old_dst_i        (old_dst),
        .upper_half_i     (upper_half),
        .vector_mode_i    (vector_mode),
        .merge_en_i       (merge_en),
        .out_valid_o      (out_valid),
        .dst_o            (dst),
        .flag_inexact_o   (f_nx),
        .flag_overflow_o  (f_of),
        .flag_underflow_o (f_uf),
        .flag_invalid_o   (f_nv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: returns {nx, of, uf, nv, result[31:0]}
    function automatic logic [35:0] ref_cvt(input logic [63:0] d);
        logic        s;
        int          e, p, t, drop, sh, ex;
        logic [63:0] m, fr;
        logic        st;
        s = d[63];
        e = int'(d[62:52]);
        if (e == 2047) begin
            if (d[51:0] == '0) return {4'b0000, s, 8'hFF, 23'h0};
            return {3'b000, ~d[51], s, 8'hFF, 1'b1, d[50:29]};
        end
        if (e == 0 && d[51:0] == '0) return {4'b0000, s, 31'h0};
        m  = {11'h0, (e != 0), d[51:0]};
        ex = (e == 0) ? 1 : e;
        p  = 0;
        for (int i = 0; i < 53; i++) if (m[i]) p = i;
        t = p + ex - 1075;
        if (t > 127) return {4'b1100, s, 8'hFE, 23'h7FFFFF};
        if (t >= -126) begin
            drop = p - 23;
            fr   = m >> drop;
            st   = (m & ((64'd1 << drop) - 64'd1)) != 0;
            return {st, 3'b000, s, 8'(t + 127), fr[22:1], fr[0] | st};
        end
        sh = 926 - ex;
        if (sh >= 64) begin
            fr = '0;
            st = (m != 0);
        end else begin
            fr = m >> sh;
            st = (m & ((64'd1 << sh) - 64'd1)) != 0;
        end
        return {st, 1'b0, st, 1'b0, s, 8'h00, fr[22:1], fr[0] | st};
    endfunction

    task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Drive one request, then check destination, flags and valid
    task automatic run_op(input string req, input logic [127:0] s_in,
                          input logic [127:0] o_in, input logic up,
                          input logic vec, input logic mg);
        logic [35:0]  r0, r1;
        logic [127:0] e_dst;
        logic [3:0]   e_fl;
        @(negedge clk);
        src = s_in; old_dst = o_in; upper_half = up;
        vector_mode = vec; merge_en = mg; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        r0 = ref_cvt(s_in[63:0]);
        r1 = ref_cvt(s_in[127:64]);
        if (vec) begin
            e_fl  = r0[35:32] | r1[35:32];
            e_dst = up ? {r1[31:0], r0[31:0], o_in[63:0]} : {64'h0, r1[31:0], r0[31:0]};
        end else begin
            e_fl  = r0[35:32];
            e_dst = mg ? {o_in[127:32], r0[31:0]} : {96'h0, r0[31:0]};
        end
        chk({req, " dst"}, dst, e_dst);
        chk({req, " flags"}, {124'h0, f_nx, f_of, f_uf, f_nv}, {124'h0, e_fl});
        chk({req, " R12 valid"}, {127'h0, out_valid}, 128'h1);
    endtask

    localparam logic [127:0] OLD = 128'hA5A5_5A5A_1234_5678_9ABC_DEF0_0F1E_2D3C;

    task automatic t_reset();
        chk("R12 reset valid", {127'h0, out_valid}, 128'h0);
        chk("R12 reset dst", dst, 128'h0);
        chk("R12 reset flags", {124'h0, f_nx, f_of, f_uf, f_nv}, 128'h0);
    endtask

    task automatic t_exact();
        run_op("R1 exact 1.5/-2.0", {64'hC000000000000000, 64'h3FF8000000000000}, OLD, 0, 1, 0);
        chk("R1 lane0 hardcoded", {96'h0, dst[31:0]}, {96'h0, 32'h3FC00000});
        chk("R1 lane1 hardcoded", {96'h0, dst[63:32]}, {96'h0, 32'hC0000000});
        run_op("R1 max finite exact", {64'h47EFFFFFE0000000, 64'h3FF0000000000000}, OLD, 0, 1, 0);
    endtask

    task automatic t_inexact();
        run_op("R2 lsb lost", {64'h3FD5555555555555, 64'h3FF0000000000001}, OLD, 0, 1, 0);
        chk("R2 forced odd", {96'h0, dst[31:0]}, {96'h0, 32'h3F800001});
        run_op("R2 halfway", {64'h3FF0000000000000, 64'h3FF0000010000000}, OLD, 0, 1, 0);
        chk("R2 halfway odd", {96'h0, dst[31:0]}, {96'h0, 32'h3F800001});
    endtask

    task automatic t_overflow();
        run_op("R3 overflow 2^128/-huge", {64'hFE00000000000000, 64'h47F0000000000000}, OLD, 0, 1, 0);
        chk("R3 sat pos", {96'h0, dst[31:0]}, {96'h0, 32'h7F7FFFFF});
        chk("R3 sat neg", {96'h0, dst[63:32]}, {96'h0, 32'hFF7FFFFF});
    endtask

    task automatic t_subnormal();
        run_op("R4 exact subnormals", {64'h36A0000000000000, 64'h3800000000000000}, OLD, 0, 1, 0);
        chk("R4 2^-127", {96'h0, dst[31:0]}, {96'h0, 32'h00400000});
        run_op("R4 tiny inexact", {64'h36A8000000000000, 64'h3690000000000000}, OLD, 0, 1, 0);
        chk("R4 2^-150 odd", {96'h0, dst[31:0]}, {96'h0, 32'h00000001});
        run_op("R5 wide subnormal", {64'h000FFFFFFFFFFFFF, 64'h8000000000000001}, OLD, 0, 1, 0);
        chk("R5 min subnormal", {96'h0, dst[31:0]}, {96'h0, 32'h80000001});
    endtask

    task automatic t_special();
        run_op("R6 quiet/signalling NaN", {64'hFFF4000000000000, 64'h7FF8F00000000123}, OLD, 0, 1, 0);
        chk("R6 snan invalid", {127'h0, f_nv}, 128'h1);
        run_op("R6 quiet only", {64'h7FFC000020000000, 64'h7FF8F00000000123}, OLD, 0, 1, 0);
        chk("R6 qnan no invalid", {127'h0, f_nv}, 128'h0);
        run_op("R7 inf and zero", {64'h8000000000000000, 64'hFFF0000000000000}, OLD, 0, 1, 0);
        chk("R7 -inf", {96'h0, dst[31:0]}, {96'h0, 32'hFF800000});
        chk("R7 -0", {96'h0, dst[63:32]}, {96'h0, 32'h80000000});
    endtask

    task automatic t_placement();
        run_op("R8 lower half", {64'h3FD5555555555555, 64'h3FF8000000000000}, OLD, 0, 1, 1);
        run_op("R9 upper half", {64'h3FD5555555555555, 64'h3FF8000000000000}, OLD, 1, 1, 0);
        chk("R9 low kept", {64'h0, dst[63:0]}, {64'h0, OLD[63:0]});
    endtask

    task automatic t_scalar();
        run_op("R10 merge on", {64'hFFF4000000000000, 64'h3FF0000000000001}, OLD, 0, 0, 1);
        chk("R11 lane1 snan ignored", {127'h0, f_nv}, 128'h0);
        run_op("R10 merge off", {64'h47F0000000000000, 64'h3FF8000000000000}, OLD, 0, 0, 0);
        chk("R11 lane1 ovf ignored", {127'h0, f_of}, 128'h0);
        run_op("R10 upper ignored", {64'h3FF0000000000001, 64'hC000000000000000}, OLD, 1, 0, 1);
        chk("R10 upper ignored low", {96'h0, dst[31:0]}, {96'h0, 32'hC0000000});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_exact();
        t_inexact();
        t_overflow();
        t_subnormal();
        t_special();
        t_placement();
        t_scalar();
        @(negedge clk);
        chk("R12 valid one cycle", {127'h0, out_valid}, 128'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired got=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule